// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire (I2C-compatible) slave that owns a small bank of byte-wide configuration registers and one read-only status byte. It recognises only 7-bit addressing. A strap input picks one of two device addresses. A host writes the address byte, then a register pointer, then any number of data bytes. It reads by setting the pointer in a write phase, then issuing a repeated START with the read address and clocking bytes out. The pointer advances after every data byte in both directions.

Writes are staged in a shadow copy and reach the live register outputs only when a STOP ends the transfer. A repeated START throws away whatever the current write phase has staged, so a host can abandon a partial update safely. SCL and SDA are sampled by a faster system clock. The block's only SDA output is a pull-low request for an external open-drain pad.

Top module: `i2c_cfg_regfile`

## Requirements
- R1: After reset, live register n (0 to 13) holds (37*n + 3) mod 256 and the SDA pull-low output is released.
- R2: With the strap low the slave answers the 7-bit address 4Ah (write byte 94h, read byte 95h). With the strap high it answers 4Bh (96h, 97h). A matching address byte is acknowledged by pulling SDA low during the ninth clock.
- R3: Any other address byte, including the general call 00h and the 10-bit prefix 11110xxb, gets no acknowledge. The slave then ignores the bus until the next START.
- R4: In a write, the byte after the address is the register pointer and the bytes after that are data. The slave acknowledges every one of these bytes.
- R5: The pointer advances by one after each data byte, read or written, and wraps from FFh to 00h.
- R6: Data written to registers 00h to 0Dh appears on the live outputs only after a STOP, one clock after the STOP is detected. Before that, the live outputs keep their old values.
- R7: A START or repeated START discards every write staged since the previous START, so a write phase ended by a repeated START changes no live register.
- R8: A read returns the committed value at the pointer, MSB first. The slave sends further bytes while the master acknowledges and stops sending after a master not-acknowledge.
- R9: Pointer 0Eh reads the external status input, and pointers 0Fh and above read 00h. Writes to 0Eh and above are acknowledged and discarded.
- R10: The slave raises its SDA pull only while SCL is low, and releases it after a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel_i | input | 1 | Address strap: 0 selects 4Ah, 1 selects 4Bh |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| status_i | input | 8 | Status byte returned at pointer 0Eh |
| sda_pull_o | output | 1 | 1 asks the pad to drive SDA low |
| cfg_o | output | 112 | Live registers, register n at bits [8n+7:8n] |

## Verification
A wrong pointer or bit counter shows at the ports within one byte time. The wrong register changes on the live outputs after the next STOP, or a read returns a byte that does not match the committed model. Acknowledge bits are sampled on every byte, so a protocol state that slips by one clock is seen as a missing or misplaced pull on the ninth clock of that same byte. The outputs are compared against the model before and after every STOP and repeated START. A staging or discard fault therefore appears at the first STOP that follows it.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam logic [6:0] DEV_ADDR_BASE = 7'h4A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_END,
        ST_ACK,
        ST_TX,
        ST_MACK
    } link_st_e;

    typedef enum logic [1:0] {
        RX_ADDR,
        RX_PTR,
        RX_DATA
    } rx_kind_e;

    function automatic logic [BYTE_W-1:0] reset_value(input int idx);
        return BYTE_W'((idx * 37 + 3) % 256);
    endfunction

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);
    typedef struct packed {
        logic scl_m;
        logic sda_m;
        logic scl_s;
        logic sda_s;
        logic scl_p;
        logic sda_p;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d       = smp_q;
        smp_d.scl_m = scl_i;
        smp_d.sda_m = sda_i;
        smp_d.scl_s = smp_q.scl_m;
        smp_d.sda_s = smp_q.sda_m;
        smp_d.scl_p = smp_q.scl_s;
        smp_d.sda_p = smp_q.sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign scl_rise  = smp_q.scl_s & ~smp_q.scl_p;
    assign scl_fall  = ~smp_q.scl_s & smp_q.scl_p;
    assign start_det = smp_q.scl_s & smp_q.scl_p & smp_q.sda_p & ~smp_q.sda_s;
    assign stop_det  = smp_q.scl_s & smp_q.scl_p & ~smp_q.sda_p & smp_q.sda_s;
    assign sda_s     = smp_q.sda_s;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_cfg_pkg::*;
#(
    parameter int NUM_REGS = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [BYTE_W-1:0]          wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic                       commit,
    input  logic                       discard,
    input  logic [BYTE_W-1:0]          rd_idx,
    input  logic [BYTE_W-1:0]          status_i,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] live_o,
    output logic [NUM_REGS-1:0]        dirty_o
);
    localparam int IDX_W = $clog2(NUM_REGS + 1);
    localparam logic [BYTE_W-1:0] LAST_IDX = BYTE_W'(NUM_REGS);

    typedef struct packed {
        logic [NUM_REGS-1:0][BYTE_W-1:0] live;
        logic [NUM_REGS-1:0][BYTE_W-1:0] shadow;
        logic [NUM_REGS-1:0]             dirty;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_REGS-1:0][BYTE_W-1:0] rst_vals;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        assign rst_vals[g] = reset_value(g);
        assign live_o[g*BYTE_W +: BYTE_W] = bank_q.live[g];
    end

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (wr_idx < LAST_IDX)) begin
            bank_d.shadow[wr_idx[IDX_W-1:0]] = wr_data;
            bank_d.dirty[wr_idx[IDX_W-1:0]]  = 1'b1;
        end
        if (commit) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (bank_q.dirty[i]) bank_d.live[i] = bank_q.shadow[i];
            end
            bank_d.dirty = '0;
        end
        if (discard) begin
            bank_d.dirty = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.live   <= rst_vals;
            bank_q.shadow <= rst_vals;
            bank_q.dirty  <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        if (rd_idx < LAST_IDX)       rd_data = bank_q.live[rd_idx[IDX_W-1:0]];
        else if (rd_idx == LAST_IDX) rd_data = status_i;
        else                         rd_data = '0;
    end

    assign dirty_o = bank_q.dirty;

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_BASE = DEV_ADDR_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel_i,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_idx,
    output logic              sda_pull_o
);
    localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

    typedef struct packed {
        link_st_e          st;
        rx_kind_e          kind;
        logic [2:0]        cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] ptr;
        logic              is_read;
        logic              pull;
        logic              mack_ok;
    } link_t;

    link_t lk_d, lk_q;
    logic [6:0] my_addr;

    assign my_addr = {DEV_BASE[6:1], addr_sel_i};

    always_comb begin
        lk_d  = lk_q;
        wr_en = 1'b0;
        if (start_det) begin
            lk_d.st      = ST_RX;
            lk_d.kind    = RX_ADDR;
            lk_d.cnt     = '0;
            lk_d.pull    = 1'b0;
            lk_d.is_read = 1'b0;
        end else if (stop_det) begin
            lk_d.st   = ST_IDLE;
            lk_d.pull = 1'b0;
        end else begin
            unique case (lk_q.st)
                ST_IDLE: ;
                ST_RX: begin
                    if (scl_rise) begin
                        lk_d.shreg = {lk_q.shreg[BYTE_W-2:0], sda_s};
                        lk_d.cnt   = lk_q.cnt + 3'd1;
                        if (lk_q.cnt == LAST_BIT) lk_d.st = ST_RX_END;
                    end
                end
                ST_RX_END: begin
                    if (scl_fall) begin
                        unique case (lk_q.kind)
                            RX_ADDR: begin
                                if (lk_q.shreg[7:1] == my_addr) begin
                                    lk_d.pull    = 1'b1;
                                    lk_d.st      = ST_ACK;
                                    lk_d.is_read = lk_q.shreg[0];
                                    lk_d.kind    = RX_PTR;
                                end else begin
                                    lk_d.st = ST_IDLE;
                                end
                            end
                            RX_PTR: begin
                                lk_d.ptr  = lk_q.shreg;
                                lk_d.pull = 1'b1;
                                lk_d.st   = ST_ACK;
                                lk_d.kind = RX_DATA;
                            end
                            default: begin
                                wr_en     = 1'b1;
                                lk_d.ptr  = lk_q.ptr + 8'd1;
                                lk_d.pull = 1'b1;
                                lk_d.st   = ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        lk_d.cnt = '0;
                        if (lk_q.is_read) begin
                            lk_d.shreg = {rd_data[BYTE_W-2:0], 1'b0};
                            lk_d.pull  = ~rd_data[BYTE_W-1];
                            lk_d.ptr   = lk_q.ptr + 8'd1;
                            lk_d.st    = ST_TX;
                        end else begin
                            lk_d.pull = 1'b0;
                            lk_d.st   = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (lk_q.cnt == LAST_BIT) begin
                            lk_d.pull    = 1'b0;
                            lk_d.mack_ok = 1'b0;
                            lk_d.st      = ST_MACK;
                        end else begin
                            lk_d.pull  = ~lk_q.shreg[BYTE_W-1];
                            lk_d.shreg = {lk_q.shreg[BYTE_W-2:0], 1'b0};
                            lk_d.cnt   = lk_q.cnt + 3'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        lk_d.mack_ok = ~sda_s;
                        if (sda_s) lk_d.st = ST_IDLE;
                    end else if (scl_fall && lk_q.mack_ok) begin
                        lk_d.cnt   = '0;
                        lk_d.shreg = {rd_data[BYTE_W-2:0], 1'b0};
                        lk_d.pull  = ~rd_data[BYTE_W-1];
                        lk_d.ptr   = lk_q.ptr + 8'd1;
                        lk_d.st    = ST_TX;
                    end
                end
                default: lk_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q.st      <= ST_IDLE;
            lk_q.kind    <= RX_ADDR;
            lk_q.cnt     <= '0;
            lk_q.shreg   <= '0;
            lk_q.ptr     <= '0;
            lk_q.is_read <= 1'b0;
            lk_q.pull    <= 1'b0;
            lk_q.mack_ok <= 1'b0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign wr_idx     = lk_q.ptr;
    assign wr_data    = lk_q.shreg;
    assign rd_idx     = lk_q.ptr;
    assign sda_pull_o = lk_q.pull;

endmodule

// File: rtl/i2c_cfg_regfile.sv
module i2c_cfg_regfile
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_REGS = 14,
    parameter logic [6:0] DEV_BASE = DEV_ADDR_BASE
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       addr_sel_i,
    input  logic                       scl_i,
    input  logic                       sda_i,
    input  logic [BYTE_W-1:0]          status_i,
    output logic                       sda_pull_o,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
    logic              scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_idx, wr_data, rd_idx, rd_data;
    logic [NUM_REGS-1:0] dirty_mask;

    i2c_bus_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s)
    );

    i2c_link_fsm #(.DEV_BASE(DEV_BASE)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_sel_i (addr_sel_i),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sda_s      (sda_s),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .sda_pull_o (sda_pull_o)
    );

    i2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .commit   (stop_det),
        .discard  (start_det),
        .rd_idx   (rd_idx),
        .status_i (status_i),
        .rd_data  (rd_data),
        .live_o   (cfg_o),
        .dirty_o  (dirty_mask)
    );

endmodule

// File: rtl/i2c_cfg_regfile_chk.sv
module i2c_cfg_regfile_chk #(
    parameter int NUM_REGS = 14
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_pull_o,
    input logic [NUM_REGS*8-1:0] cfg_o,
    input logic                  start_det,
    input logic                  stop_det,
    input logic [NUM_REGS-1:0]   dirty
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_released_r1: assert (sda_pull_o == 1'b0)
                else $error("SDA pull active during reset");
        end
    end

    p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i);

    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_pull_o);

    p_live_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(stop_det));

    p_start_discards_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det) |-> (dirty == '0));

    p_stop_clears_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> (dirty == '0));

endmodule

bind i2c_cfg_regfile i2c_cfg_regfile_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_pull_o (sda_pull_o),
    .cfg_o      (cfg_o),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .dirty      (dirty_mask)
);

// File: tb/test_i2c_cfg_regfile.sv
module test_i2c_cfg_regfile;

    localparam int NREG = 14;
    localparam int Q    = 5;
    localparam int H    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [7:0] status_tb = 8'hC3;
    logic sda_pull;
    logic [NREG*8-1:0] cfg;
    wire  sda_line = sda_m & ~sda_pull;

    int checks = 0;
    int failures = 0;
    int r10_viol = 0;
    logic pull_prev = 1'b0;
    logic [7:0] mdl [NREG];
    logic [7:0] wbuf [8];

    always #5 clk = ~clk;

    i2c_cfg_regfile i_i2c_cfg_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_sel_i (addr_sel),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .status_i   (status_tb),
        .sda_pull_o (sda_pull),
        .cfg_o      (cfg)
    );

    // R10 monitor: the pull may only rise while SCL is low
    always @(posedge clk) begin
        if (rst_n && sda_pull && !pull_prev && scl) r10_viol++;
        pull_prev <= sda_pull;
    end

    function automatic logic [7:0] rst_val(input int n);
        return 8'((n * 37 + 3) % 256);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] idx);
        if (idx < 8'(NREG))       return mdl[idx[3:0]];
        else if (idx == 8'(NREG)) return status_tb;
        else                      return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_start();
        sda_m = 1'b1; wt(Q);
        scl = 1'b1;   wt(H);
        sda_m = 1'b0; wt(H);
        scl = 1'b0;   wt(Q);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wt(Q);
        scl = 1'b1;   wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(Q);
            scl = 1'b1;   wt(H);
            scl = 1'b0;   wt(Q);
        end
        sda_m = 1'b1; wt(Q);
        scl = 1'b1;   wt(H / 2);
        ack = ~sda_line;
        wt(H / 2);
        scl = 1'b0;   wt(Q);
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q);
            scl = 1'b1; wt(H / 2);
            b[i] = sda_line;
            wt(H / 2);
            scl = 1'b0; wt(Q);
        end
        sda_m = mack ? 1'b0 : 1'b1; wt(Q);
        scl = 1'b1; wt(H);
        scl = 1'b0; wt(Q);
        sda_m = 1'b1;
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NREG; i++) chk(req, cfg[i*8 +: 8], mdl[i]);
    endtask

    function automatic logic [7:0] dev_w();
        return addr_sel ? 8'h96 : 8'h94;
    endfunction

    // Write n bytes of wbuf at ptr; rep=1 ends with a repeated START before the STOP.
    task automatic wr_txn(input logic [7:0] ptr, input int n, input logic rep);
        logic a;
        do_start();
        send_byte(dev_w(), a);  chk("R2 write address ack", a, 1);
        send_byte(ptr, a);      chk("R4 pointer ack", a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); chk("R4 data ack", a, 1);
        end
        check_all("R6 live unchanged before STOP");
        if (rep) do_start();
        do_stop();
        if (!rep) begin
            for (int i = 0; i < n; i++) begin
                logic [7:0] idx = ptr + 8'(i);
                if (idx < 8'(NREG)) mdl[idx[3:0]] = wbuf[i];
            end
        end
        wt(4);
        check_all(rep ? "R7 repeated START discards" : "R6 R5 commit at STOP");
    endtask

    task automatic rd_txn(input logic [7:0] ptr, input int n);
        logic a;
        logic [7:0] b;
        do_start();
        send_byte(dev_w(), a);         chk("R2 write address ack", a, 1);
        send_byte(ptr, a);             chk("R4 pointer ack", a, 1);
        do_start();
        send_byte(dev_w() | 8'h01, a); chk("R2 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] idx = ptr + 8'(i);
            read_byte(i != n - 1, b);
            chk(idx >= 8'(NREG) ? "R9 status/unmapped read" : "R8 read R5 increment",
                b, exp_read(idx));
        end
        do_stop();
        wt(4);
    endtask

    initial begin
        logic a;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NREG; i++) mdl[i] = rst_val(i);
        wt(5);
        chk("R1 pull released in reset", sda_pull, 0);
        rst_n = 1'b1;
        wt(5);
        check_all("R1 reset values");

        // R2: strap selects the address
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
        wr_txn(8'h02, 2, 1'b0);
        addr_sel = 1'b1;
        do_start(); send_byte(8'h94, a); chk("R2 other strap address nack", a, 0); do_stop();
        wbuf[0] = 8'h77;
        wr_txn(8'h00, 1, 1'b0);
        addr_sel = 1'b0;
        do_start(); send_byte(8'h96, a); chk("R2 other strap address nack", a, 0); do_stop();

        // R3: general call and 10-bit prefix are ignored
        do_start();
        send_byte(8'h00, a); chk("R3 general call nack", a, 0);
        send_byte(8'h03, a); chk("R3 ignored until START", a, 0);
        send_byte(8'h55, a); chk("R3 ignored until START", a, 0);
        do_stop(); wt(4);
        check_all("R3 no register change");
        do_start(); send_byte(8'hF0, a); chk("R3 ten-bit prefix nack", a, 0); do_stop();

        // R7: write abandoned by repeated START
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        wr_txn(8'h05, 2, 1'b1);

        // R5: pointer wrap FFh -> 00h
        wbuf[0] = 8'hEE; wbuf[1] = 8'h01; wbuf[2] = 8'h02;
        wr_txn(8'hFF, 3, 1'b0);

        // R9: writes at 0Eh and beyond discarded, reads of status and unmapped
        wbuf[0] = 8'h99; wbuf[1] = 8'h98;
        wr_txn(8'h0D, 2, 1'b0);
        rd_txn(8'h0C, 4);
        status_tb = 8'h5A;
        rd_txn(8'h0E, 1);

        // R8: multi-byte read across the bank
        rd_txn(8'h00, 5);

        // randomized traffic
        for (int it = 0; it < 24; it++) begin
            logic [7:0] p = 8'($urandom_range(0, 16));
            int n = int'($urandom_range(1, 4));
            logic rep = ($urandom_range(0, 3) == 0);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            addr_sel = 1'($urandom);
            wr_txn(p, n, rep);
            status_tb = 8'($urandom);
            rd_txn(8'($urandom_range(0, 15)), 2);
        end

        chk("R10 pull rose while SCL high", r10_viol, 0);
        chk("R10 pull released when idle", sda_pull, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule